// File: doc/BRIEF.md
# Cathode Half-Strip Stub Finder

This block looks for short straight-ish track segments ("stubs") in a detector made of six stacked strip layers. In every bunch crossing it receives one hit bit per half-strip for each layer. It also folds each group of four neighbouring half-strips into one coarse di-strip bit, so that tracks bending too far for the fine grid can still be caught. Around every key position on the third layer it counts, for a fixed set of pattern envelopes, how many layers carry a hit. It does this for half-strip and di-strip resolution at the same time.

When any count reaches the pre-trigger level, a wait of a programmable number of crossings starts. At the end of the wait the counts are taken again, and candidates that reach the trigger level are ranked. Up to two stubs are reported in registered outputs, each with a valid flag, resolution type, key, pattern number and quality. The second stub may not sit next to the first. The block sits between the per-layer hit encoders and the chamber-level coincidence logic.

Top module: `cathode_stub_finder`

## Requirements
- R1: While reset is high and on the first edge after it, both stub valid outputs are 0.
- R2: Input bit `l*NUM_HS + h` is the hit of half-strip h on layer l (l = 0..5, layer index 2 is the key layer). Di-strip d on layer l is the OR of half-strips 4d to 4d+3 of that layer.
- R3: Pattern p (0..4) has slope d = 0, +1, -1, +2, -2 for p = 4, 3, 2, 1, 0. On layer l it looks at position key + clip((d*(l-2))/2, -2, +2), with division truncating toward zero. Positions outside the array count as no hit. The layer count of (key, p) is the number of layers hit at those positions, in half-strip units for half-strip keys and di-strip units for di-strip keys. Each key keeps its largest count, and on a tie the highest p.
- R4: A pre-trigger starts when some key of either resolution has a layer count of at least `pre_layers` in the latched hits. Without a pre-trigger no stub is ever reported.
- R5: If hits latched on edge E cause a pre-trigger, the outputs are updated on edge E + `wait_bx` + 1. They are computed from the hits latched on edge E + `wait_bx`. Hits latched during the wait do not start another evaluation.
- R6: A candidate is reported only if its layer count is at least `trig_layers` (and at least 1). If no candidate qualifies, the evaluation reports nothing.
- R7: Ranking puts any half-strip candidate ahead of any di-strip candidate, then more layers ahead of fewer, then the higher pattern number, and then the lower key. Stub 0 is the best candidate.
- R8: Stub 1 is the best candidate not near stub 0. Near means that, for the same resolution, the keys differ by at most 2. Across resolutions it means the half-strip key divided by 4 differs from the di-strip key by at most 2. Stub 1 is valid only if stub 0 is valid.
- R9: Reported quality is the layer count minus 3, or 0 when fewer than 3 layers are hit. The type output is 1 for half-strip and 0 for di-strip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| hits_in | input | 6*NUM_HS | Half-strip hit bits, layer-major |
| pre_layers | input | 3 | Minimum layer count for pre-trigger |
| trig_layers | input | 3 | Minimum layer count for a stub |
| wait_bx | input | DW | Crossings between pre-trigger and evaluation |
| s0_vld | output | 1 | Best stub valid |
| s0_hs | output | 1 | Best stub is half-strip (1) or di-strip (0) |
| s0_key | output | KW | Best stub key in its own resolution |
| s0_pat | output | 3 | Best stub pattern number |
| s0_qual | output | 3 | Best stub quality |
| s1_vld | output | 1 | Second stub valid |
| s1_hs | output | 1 | Second stub type |
| s1_key | output | KW | Second stub key |
| s1_pat | output | 3 | Second stub pattern number |
| s1_qual | output | 3 | Second stub quality |

## Verification
The hardest case to reach is an evaluation whose hits differ from the ones that fired the pre-trigger. In that case the reported stub must come from the later hits. The bench holds a weak two-layer pattern for one crossing and then swaps in a strong track for the rest of the wait. This is repeated for several wait lengths. Steeply bending tracks are placed so that only the di-strip envelopes collect six layers, with each hit shifted around inside its four-half-strip group. Random hit maps, swept over thresholds and waits, exercise the cross-resolution exclusion.

// File: rtl/cstub_pkg.sv
package cstub_pkg;
  localparam int NLAYER   = 6;
  localparam int KEY_LYR  = 2;
  localparam int NPAT     = 5;
  localparam int SPAN     = 2;
  localparam int GROUP    = 4;
  localparam int CW       = 3;
  localparam int PW       = 3;

  typedef enum logic [0:0] {SQ_IDLE, SQ_WAIT} seq_t;

  function automatic int pat_slope(int p);
    case (p)
      4:       return 0;
      3:       return 1;
      2:       return -1;
      1:       return 2;
      default: return -2;
    endcase
  endfunction

  function automatic int pat_off(int p, int l);
    int v;
    v = (pat_slope(p) * (l - KEY_LYR)) / 2;
    if (v > SPAN)  v = SPAN;
    if (v < -SPAN) v = -SPAN;
    return v;
  endfunction
endpackage

// File: rtl/cstub_front.sv
module cstub_front
  import cstub_pkg::*;
#(
  parameter int NUM_HS = 160,
  localparam int NUM_DS = NUM_HS / GROUP
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NLAYER*NUM_HS-1:0]            hits_in,
  output logic [NLAYER-1:0][NUM_HS-1:0]       hs_q,
  output logic [NLAYER-1:0][NUM_DS-1:0]       ds_bits
);
  always_ff @(posedge clk) begin
    if (rst) hs_q <= '0;
    else begin
      for (int l = 0; l < NLAYER; l++) hs_q[l] <= hits_in[l*NUM_HS +: NUM_HS];
    end
  end

  for (genvar l = 0; l < NLAYER; l++) begin : g_lyr
    for (genvar d = 0; d < NUM_DS; d++) begin : g_ds
      assign ds_bits[l][d] = |hs_q[l][d*GROUP +: GROUP];
    end
  end
endmodule

// File: rtl/cstub_counter.sv
module cstub_counter
  import cstub_pkg::*;
#(
  parameter int NPOS = 160
) (
  input  logic [NLAYER-1:0][NPOS-1:0] bits,
  output logic [NPOS-1:0][CW-1:0]     best_cnt,
  output logic [NPOS-1:0][PW-1:0]     best_pat
);
  localparam int WW = 2*SPAN + 1;

  logic [NLAYER-1:0][NPOS+2*SPAN-1:0] pad;
  always_comb begin
    for (int l = 0; l < NLAYER; l++) pad[l] = {{SPAN{1'b0}}, bits[l], {SPAN{1'b0}}};
  end

  for (genvar k = 0; k < NPOS; k++) begin : g_key
    logic [NLAYER-1:0][WW-1:0] win;
    logic [CW-1:0] kc;
    logic [PW-1:0] kp;
    always_comb begin
      logic [CW-1:0] c;
      for (int l = 0; l < NLAYER; l++) win[l] = pad[l][k +: WW];
      kc = '0;
      kp = '0;
      for (int p = 0; p < NPAT; p++) begin
        c = '0;
        for (int l = 0; l < NLAYER; l++)
          c = c + CW'(win[l][3'(pat_off(p, l) + SPAN)]);
        if (c >= kc) begin
          kc = c;
          kp = PW'(p);
        end
      end
    end
    assign best_cnt[k] = kc;
    assign best_pat[k] = kp;
  end
endmodule

// File: rtl/cstub_ranker.sv
module cstub_ranker
  import cstub_pkg::*;
#(
  parameter int NUM_HS = 160,
  parameter int KW     = 8,
  localparam int NUM_DS = NUM_HS / GROUP
) (
  input  logic [NUM_HS-1:0][CW-1:0] hs_cnt,
  input  logic [NUM_HS-1:0][PW-1:0] hs_pat,
  input  logic [NUM_DS-1:0][CW-1:0] ds_cnt,
  input  logic [NUM_DS-1:0][PW-1:0] ds_pat,
  input  logic [CW-1:0]             trig_layers,
  output logic                      f0, t0, f1, t1,
  output logic [KW-1:0]             k0, k1,
  output logic [CW-1:0]             c0, c1,
  output logic [PW-1:0]             p0, p1
);
  function automatic logic near(logic ta, int ka, logic tb, int kb);
    int a, b;
    a = (ta != tb && ta) ? ka / GROUP : ka;
    b = (ta != tb && tb) ? kb / GROUP : kb;
    return (a - b <= 2) && (b - a <= 2);
  endfunction

  function automatic logic ok(logic [CW-1:0] c, logic [CW-1:0] thr);
    return (c >= thr) && (c != '0);
  endfunction

  logic [CW+PW:0] r0, r1;

  always_comb begin
    f0 = 1'b0; t0 = 1'b0; k0 = '0; c0 = '0; p0 = '0; r0 = '0;
    for (int k = 0; k < NUM_HS; k++)
      if (ok(hs_cnt[k], trig_layers) && (!f0 || {1'b1, hs_cnt[k], hs_pat[k]} > r0)) begin
        f0 = 1'b1; t0 = 1'b1; k0 = KW'(k); c0 = hs_cnt[k]; p0 = hs_pat[k];
        r0 = {1'b1, hs_cnt[k], hs_pat[k]};
      end
    for (int k = 0; k < NUM_DS; k++)
      if (ok(ds_cnt[k], trig_layers) && (!f0 || {1'b0, ds_cnt[k], ds_pat[k]} > r0)) begin
        f0 = 1'b1; t0 = 1'b0; k0 = KW'(k); c0 = ds_cnt[k]; p0 = ds_pat[k];
        r0 = {1'b0, ds_cnt[k], ds_pat[k]};
      end
  end

  always_comb begin
    f1 = 1'b0; t1 = 1'b0; k1 = '0; c1 = '0; p1 = '0; r1 = '0;
    if (f0) begin
      for (int k = 0; k < NUM_HS; k++)
        if (ok(hs_cnt[k], trig_layers) && !near(t0, int'(k0), 1'b1, k) &&
            (!f1 || {1'b1, hs_cnt[k], hs_pat[k]} > r1)) begin
          f1 = 1'b1; t1 = 1'b1; k1 = KW'(k); c1 = hs_cnt[k]; p1 = hs_pat[k];
          r1 = {1'b1, hs_cnt[k], hs_pat[k]};
        end
      for (int k = 0; k < NUM_DS; k++)
        if (ok(ds_cnt[k], trig_layers) && !near(t0, int'(k0), 1'b0, k) &&
            (!f1 || {1'b0, ds_cnt[k], ds_pat[k]} > r1)) begin
          f1 = 1'b1; t1 = 1'b0; k1 = KW'(k); c1 = ds_cnt[k]; p1 = ds_pat[k];
          r1 = {1'b0, ds_cnt[k], ds_pat[k]};
        end
    end
  end
endmodule

// File: rtl/cathode_stub_finder.sv
module cathode_stub_finder
  import cstub_pkg::*;
#(
  parameter int NUM_HS = 160,
  parameter int DW     = 3,
  localparam int NUM_DS = NUM_HS / GROUP,
  localparam int KW     = $clog2(NUM_HS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NLAYER*NUM_HS-1:0] hits_in,
  input  logic [CW-1:0]            pre_layers,
  input  logic [CW-1:0]            trig_layers,
  input  logic [DW-1:0]            wait_bx,
  output logic                     s0_vld,
  output logic                     s0_hs,
  output logic [KW-1:0]            s0_key,
  output logic [PW-1:0]            s0_pat,
  output logic [CW-1:0]            s0_qual,
  output logic                     s1_vld,
  output logic                     s1_hs,
  output logic [KW-1:0]            s1_key,
  output logic [PW-1:0]            s1_pat,
  output logic [CW-1:0]            s1_qual
);
  logic [NLAYER-1:0][NUM_HS-1:0] hs_q;
  logic [NLAYER-1:0][NUM_DS-1:0] ds_bits;
  logic [NUM_HS-1:0][CW-1:0]     hs_cnt;
  logic [NUM_HS-1:0][PW-1:0]     hs_pat;
  logic [NUM_DS-1:0][CW-1:0]     ds_cnt;
  logic [NUM_DS-1:0][PW-1:0]     ds_pat;
  logic f0, t0, f1, t1;
  logic [KW-1:0] k0, k1;
  logic [CW-1:0] c0, c1;
  logic [PW-1:0] p0, p1;

  cstub_front #(.NUM_HS(NUM_HS)) u_front (
    .clk(clk), .rst(rst), .hits_in(hits_in), .hs_q(hs_q), .ds_bits(ds_bits));

  cstub_counter #(.NPOS(NUM_HS)) u_cnt_hs (
    .bits(hs_q), .best_cnt(hs_cnt), .best_pat(hs_pat));

  cstub_counter #(.NPOS(NUM_DS)) u_cnt_ds (
    .bits(ds_bits), .best_cnt(ds_cnt), .best_pat(ds_pat));

  cstub_ranker #(.NUM_HS(NUM_HS), .KW(KW)) u_rank (
    .hs_cnt(hs_cnt), .hs_pat(hs_pat), .ds_cnt(ds_cnt), .ds_pat(ds_pat),
    .trig_layers(trig_layers),
    .f0(f0), .t0(t0), .f1(f1), .t1(t1), .k0(k0), .k1(k1),
    .c0(c0), .c1(c1), .p0(p0), .p1(p1));

  // Pre-trigger: any key of either resolution at the pre-trigger level
  logic pre_any;
  always_comb begin
    pre_any = 1'b0;
    for (int k = 0; k < NUM_HS; k++) if (hs_cnt[k] >= pre_layers && hs_cnt[k] != '0) pre_any = 1'b1;
    for (int k = 0; k < NUM_DS; k++) if (ds_cnt[k] >= pre_layers && ds_cnt[k] != '0) pre_any = 1'b1;
  end

  seq_t          state;
  logic [DW-1:0] wcnt;
  logic          eval;

  assign eval = (state == SQ_IDLE && pre_any && wait_bx == '0) ||
                (state == SQ_WAIT && wcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      wcnt  <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (pre_any && wait_bx != '0) begin
          state <= SQ_WAIT;
          wcnt  <= wait_bx - 1'b1;
        end
        default: if (wcnt == '0) state <= SQ_IDLE;
                 else wcnt <= wcnt - 1'b1;
      endcase
    end
  end

  function automatic logic [CW-1:0] qual(logic [CW-1:0] c);
    return (c >= CW'(3)) ? c - CW'(3) : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_vld <= 1'b0; s0_hs <= 1'b0; s0_key <= '0; s0_pat <= '0; s0_qual <= '0;
      s1_vld <= 1'b0; s1_hs <= 1'b0; s1_key <= '0; s1_pat <= '0; s1_qual <= '0;
    end else begin
      s0_vld <= eval && f0;
      s1_vld <= eval && f1;
      if (eval) begin
        s0_hs <= t0; s0_key <= k0; s0_pat <= p0; s0_qual <= qual(c0);
        s1_hs <= t1; s1_key <= k1; s1_pat <= p1; s1_qual <= qual(c1);
      end
    end
  end
endmodule

// File: rtl/cstub_checker.sv
module cstub_checker #(
  parameter int KW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    trig_layers,
  input logic          s0_vld,
  input logic          s0_hs,
  input logic [KW-1:0] s0_key,
  input logic [2:0]    s0_pat,
  input logic [2:0]    s0_qual,
  input logic          s1_vld,
  input logic          s1_hs,
  input logic [KW-1:0] s1_key,
  input logic [2:0]    s1_pat,
  input logic [2:0]    s1_qual
);
  // R1: outputs cleared on the edge following a reset cycle
  always @(posedge clk) begin
    if ($past(rst) === 1'b1) begin
      a_reset_clear_r1: assert (!s0_vld && !s1_vld);
    end
  end

  p_second_needs_first_r8: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> s0_vld);

  p_same_type_apart_r8: assert property (@(posedge clk) disable iff (rst)
    (s0_vld && s1_vld && s0_hs == s1_hs) |->
      ((s0_key > s1_key) ? (s0_key - s1_key > 2) : (s1_key - s0_key > 2)));

  p_rank_order_r7: assert property (@(posedge clk) disable iff (rst)
    (s0_vld && s1_vld && $past(trig_layers) >= 3'd3) |->
      ({s0_hs, s0_qual, s0_pat} >= {s1_hs, s1_qual, s1_pat}));

  p_halfstrip_first_r7: assert property (@(posedge clk) disable iff (rst)
    (s0_vld && s1_vld && s1_hs) |-> s0_hs);

  p_qual_floor_r6: assert property (@(posedge clk) disable iff (rst)
    (s0_vld && $past(trig_layers) >= 3'd3) |->
      ({1'b0, s0_qual} + 4'd3 >= {1'b0, $past(trig_layers)}));
endmodule

bind cathode_stub_finder cstub_checker #(.KW(KW)) u_cstub_checker (
  .clk(clk), .rst(rst), .trig_layers(trig_layers),
  .s0_vld(s0_vld), .s0_hs(s0_hs), .s0_key(s0_key), .s0_pat(s0_pat), .s0_qual(s0_qual),
  .s1_vld(s1_vld), .s1_hs(s1_hs), .s1_key(s1_key), .s1_pat(s1_pat), .s1_qual(s1_qual));

// File: tb/test_cathode_stub_finder.sv
`timescale 1ns/1ps
module test_cathode_stub_finder;
  localparam int NHS = 16;
  localparam int NDS = 4;
  localparam int KW  = 4;
  localparam int DW  = 3;
  localparam int HW  = 6*NHS;

  logic clk = 1'b0;
  logic rst;
  logic [HW-1:0] hits;
  logic [2:0] pre_layers, trig_layers;
  logic [DW-1:0] wait_bx;
  logic s0_vld, s0_hs, s1_vld, s1_hs;
  logic [KW-1:0] s0_key, s1_key;
  logic [2:0] s0_pat, s0_qual, s1_pat, s1_qual;

  always #2 clk = ~clk;

  cathode_stub_finder #(.NUM_HS(NHS), .DW(DW)) i_cathode_stub_finder (
    .clk(clk), .rst(rst), .hits_in(hits), .pre_layers(pre_layers),
    .trig_layers(trig_layers), .wait_bx(wait_bx),
    .s0_vld(s0_vld), .s0_hs(s0_hs), .s0_key(s0_key), .s0_pat(s0_pat), .s0_qual(s0_qual),
    .s1_vld(s1_vld), .s1_hs(s1_hs), .s1_key(s1_key), .s1_pat(s1_pat), .s1_qual(s1_qual));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(bit good, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Envelope offsets as stated in R3
  function automatic int b_off(int p, int l);
    int d, v;
    case (p) 4: d = 0; 3: d = 1; 2: d = -1; 1: d = 2; default: d = -2; endcase
    v = (d * (l - 2)) / 2;
    if (v > 2) v = 2;
    if (v < -2) v = -2;
    return v;
  endfunction

  // R2: layer-major bits, di-strip = OR of four half-strips
  function automatic bit b_bit(logic [HW-1:0] v, bit hs, int l, int pos);
    if (hs) return (pos >= 0 && pos < NHS) ? v[l*NHS + pos] : 1'b0;
    return (pos >= 0 && pos < NDS) ? |v[l*NHS + 4*pos +: 4] : 1'b0;
  endfunction

  function automatic int b_best(logic [HW-1:0] v, bit hs, int k, output int bp);
    int bc = 0;
    bp = 0;
    for (int p = 0; p < 5; p++) begin
      int c = 0;
      for (int l = 0; l < 6; l++) c += int'(b_bit(v, hs, l, k + b_off(p, l)));
      if (c >= bc) begin bc = c; bp = p; end
    end
    return bc;
  endfunction

  function automatic bit b_near(bit ta, int ka, bit tb, int kb);
    int a = (ta != tb && ta) ? ka / 4 : ka;
    int b = (ta != tb && tb) ? kb / 4 : kb;
    return (a - b <= 2) && (b - a <= 2);
  endfunction

  function automatic logic [11:0] pack(bit hs, int k, int p, int c);
    return {1'b1, hs, 4'(k), 3'(p), 3'(c >= 3 ? c - 3 : 0)};
  endfunction

  // Expected stubs from R4, R6, R7, R8, R9
  function automatic void model(logic [HW-1:0] vp, logic [HW-1:0] ve, int pre, int trig,
                                output logic [11:0] e0, output logic [11:0] e1);
    bit fire = 0, f0 = 0, f1 = 0;
    int r0 = -1, r1 = -1, bt = 0, bk = 0, p, c;
    e0 = '0; e1 = '0;
    for (int t = 0; t < 2; t++)
      for (int k = 0; k < (t == 1 ? NHS : NDS); k++)
        if (b_best(vp, t[0], k, p) >= pre && b_best(vp, t[0], k, p) >= 1) fire = 1;
    if (!fire) return;
    for (int t = 1; t >= 0; t--)
      for (int k = 0; k < (t == 1 ? NHS : NDS); k++) begin
        c = b_best(ve, t[0], k, p);
        if (c >= trig && c >= 1 && (t*64 + c*8 + p) > r0) begin
          r0 = t*64 + c*8 + p; f0 = 1; bt = t; bk = k; e0 = pack(t[0], k, p, c);
        end
      end
    if (!f0) return;
    for (int t = 1; t >= 0; t--)
      for (int k = 0; k < (t == 1 ? NHS : NDS); k++) begin
        c = b_best(ve, t[0], k, p);
        if (c >= trig && c >= 1 && !b_near(bt[0], bk, t[0], k) && (t*64 + c*8 + p) > r1) begin
          r1 = t*64 + c*8 + p; f1 = 1; e1 = pack(t[0], k, p, c);
        end
      end
  endfunction

  function automatic logic [11:0] act0();
    return s0_vld ? {1'b1, s0_hs, s0_key, s0_pat, s0_qual} : 12'h0;
  endfunction
  function automatic logic [11:0] act1();
    return s1_vld ? {1'b1, s1_hs, s1_key, s1_pat, s1_qual} : 12'h0;
  endfunction

  // v0 latched first (pre-trigger), v1 held for the rest of the wait
  task automatic run(logic [HW-1:0] v0, logic [HW-1:0] v1, int pre, int trig, int w, string tag);
    logic [11:0] e0, e1;
    model(v0, (w == 0) ? v0 : v1, pre, trig, e0, e1);
    @(negedge clk);
    pre_layers = 3'(pre); trig_layers = 3'(trig); wait_bx = DW'(w);
    hits = v0;
    for (int i = 1; i <= w; i++) begin
      @(negedge clk);
      hits = v1;
    end
    @(negedge clk);
    check(!s0_vld && !s1_vld, {tag, " R5 no early stub"}, {31'b0, s0_vld}, 0);
    hits = '0;
    @(negedge clk);
    check(act0() == e0, {tag, " R7 R9 stub0"}, act0(), e0);
    check(act1() == e1, {tag, " R8 stub1"}, act1(), e1);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check(!s0_vld && !s1_vld, {tag, " R4 R5 quiet after evaluation"}, {31'b0, s0_vld}, 0);
  endtask

  function automatic logic [HW-1:0] track(bit hs, int k, int p, int j, int nl);
    logic [HW-1:0] v = '0;
    for (int l = 0; l < nl; l++) begin
      int pos = k + b_off(p, l);
      if (hs && pos >= 0 && pos < NHS) v[l*NHS + pos] = 1'b1;
      if (!hs && pos >= 0 && pos < NDS) v[l*NHS + 4*pos + ((j + l) % 4)] = 1'b1;
    end
    return v;
  endfunction

  initial begin
    #(4*200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hits = '0; pre_layers = 3'd2; trig_layers = 3'd4; wait_bx = 3'd2;
    repeat (3) @(negedge clk);
    check(!s0_vld && !s1_vld, "R1 reset", {31'b0, s0_vld | s1_vld}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!s0_vld && !s1_vld, "R1 after release", {31'b0, s0_vld | s1_vld}, 0);

    // R3 R9: straight six-layer tracks at every half-strip key
    for (int k = 0; k < NHS; k++)
      run(track(1, k, 4, 0, 6), track(1, k, 4, 0, 6), 2, 4, 2, "R3 straight");
    // R2 R3: steep tracks seen through di-strips, hit moved inside the group
    for (int d = 0; d < NDS; d++)
      for (int p = 0; p < 5; p++)
        for (int j = 0; j < 4; j++)
          run(track(0, d, p, j, 6), track(0, d, p, j, 6), 2, 4, 1, "R2 distrip");
    // R6: three layers only, trigger needs four
    run(track(1, 7, 4, 0, 3), track(1, 7, 4, 0, 3), 2, 4, 2, "R6 below trigger");
    // R4: single layer never pre-triggers
    run(track(1, 5, 4, 0, 1), track(1, 5, 4, 0, 1), 2, 1, 3, "R4 below pretrigger");
    // R5: weak hits fire the pre-trigger, a different strong track is evaluated
    for (int w = 1; w < 5; w++)
      run(track(1, 3, 4, 0, 2), track(1, 11, 3, 0, 6), 2, 4, w, "R5 late hits");
    // R7 R8: random maps over thresholds and waits
    for (int n = 0; n < 300; n++) begin
      logic [HW-1:0] v;
      int dens = 2 + (n % 6);
      int pre = 1 + (n % 3);
      int trig = pre + (n % (7 - pre));
      for (int b = 0; b < HW; b++) v[b] = ($urandom % dens) == 0;
      run(v, v, pre, trig, n % 4, "R7 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule